// File: doc/BRIEF.md
# Leaky-Bucket ECC Error Rate Counter

This block tracks corrected or detected ECC errors for a single memory rank. It reports a rate rather than a lifetime total. It keeps two registers. The first is the tally for the period in progress, C. The second is a decayed history, H. The value read out is C plus half of H.

Each time an external period timer ticks, the history absorbs the finished period: H becomes C plus half of the old H, and C restarts at zero. Older errors therefore lose weight geometrically. Software may overwrite the tally through the write port. A write also discards all history.

A comparator raises a flag whenever the current level is above a programmed threshold. Writing a large value is therefore enough to provoke the flag. Both registers are cleared only by the power-good reset. While the warm reset is asserted, the block holds its state.

Top module: `leaky_err_counter`

## Requirements
- R1: `rd_data` equals C + floor(H/2), saturated at 2^CW-1. It never wraps and never falls below C.
- R2: An `err_evt` pulse, with no tick and no write in that cycle, adds one to C at the next edge. C stays at 2^CW-1 once it reaches that value.
- R3: On `period_tick` without a write, H becomes C' + floor(H/2), saturated at 2^CW-1. C' is C plus any `err_evt` in the same cycle, also saturated. C becomes zero.
- R4: `wr_en` loads `wr_data` into C and sets H to zero. It overrides a tick and an error event in the same cycle, and that event is lost.
- R5: `over_thresh` is high in every cycle where the unsaturated sum C + floor(H/2) is strictly greater than `thresh`. This includes the cycle right after writing a value above `thresh`.
- R6: While `warm_rst_n` is low, events, ticks and writes have no effect. C and H keep their values, and so does the readout.
- R7: A low `pwr_rst_n` clears C and H. The readout is then 0, and `over_thresh` is low for any threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_rst_n | input | 1 | Power-good reset, active low, asynchronous; clears all state |
| warm_rst_n | input | 1 | Warm reset, active low; freezes state while low |
| err_evt | input | 1 | One-cycle ECC error event for this rank |
| period_tick | input | 1 | One-cycle period expiry from the external timer |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | CW | Value written into the current-period tally |
| thresh | input | CW | Error-level threshold |
| rd_data | output | CW | Leaky-bucket level C + H/2, saturated |
| over_thresh | output | 1 | Level above threshold |

## Verification
Every write value is paired with every threshold on a 4-bit configuration. This separates a strict comparison from an inclusive one and shows that a write alone raises the flag. For each starting tally, a tick is followed by runs of events long enough to saturate. Further ticks then show the halving, the rounding down and the clamp in both registers. Events are also made to coincide with a tick or a write, which exposes the priority order. Stimulus applied during a warm reset must leave the readout unchanged.

// File: rtl/leaky_err_counter.sv
module leaky_err_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          pwr_rst_n,
  input  logic          warm_rst_n,
  input  logic          err_evt,
  input  logic          period_tick,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_data,
  input  logic [CW-1:0] thresh,
  output logic [CW-1:0] rd_data,
  output logic          over_thresh
);
  localparam logic [CW:0] MAXV = {1'b0, {CW{1'b1}}};

  logic [CW-1:0] cnt_q, hist_q, cnt_sat, hist_sat;
  logic [CW:0]   cnt_inc, level, hist_nx;

  assign cnt_inc  = {1'b0, cnt_q} + {{CW{1'b0}}, err_evt};
  assign cnt_sat  = (cnt_inc > MAXV) ? MAXV[CW-1:0] : cnt_inc[CW-1:0];
  assign hist_nx  = {1'b0, cnt_sat} + {2'b00, hist_q[CW-1:1]};
  assign hist_sat = (hist_nx > MAXV) ? MAXV[CW-1:0] : hist_nx[CW-1:0];
  assign level    = {1'b0, cnt_q} + {2'b00, hist_q[CW-1:1]};

  assign rd_data     = (level > MAXV) ? MAXV[CW-1:0] : level[CW-1:0];
  assign over_thresh = level > {1'b0, thresh};

  always_ff @(posedge clk or negedge pwr_rst_n) begin
    if (!pwr_rst_n) begin
      cnt_q  <= '0;
      hist_q <= '0;
    end else if (warm_rst_n) begin
      if (wr_en) begin
        cnt_q  <= wr_data;
        hist_q <= '0;
      end else if (period_tick) begin
        hist_q <= hist_sat;
        cnt_q  <= '0;
      end else if (err_evt) begin
        cnt_q  <= cnt_sat;
      end
    end
  end
endmodule

// File: rtl/leaky_err_counter_chk.sv
module leaky_err_counter_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          pwr_rst_n,
  input logic          warm_rst_n,
  input logic          err_evt,
  input logic          period_tick,
  input logic          wr_en,
  input logic [CW-1:0] wr_data,
  input logic [CW-1:0] thresh,
  input logic [CW-1:0] rd_data,
  input logic          over_thresh,
  input logic [CW-1:0] cnt_q,
  input logic [CW-1:0] hist_q
);
  localparam int MAXI = (1 << CW) - 1;

  function automatic int sat(input int x);
    return (x > MAXI) ? MAXI : x;
  endfunction

  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    rd_data >= cnt_q);

  assert_evt_count_R2: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    warm_rst_n && err_evt && !period_tick && !wr_en |=>
      int'(cnt_q) == sat(int'($past(cnt_q)) + 1));

  assert_tick_fold_R3: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    warm_rst_n && period_tick && !wr_en |=>
      cnt_q == '0 &&
      int'(hist_q) == sat(sat(int'($past(cnt_q)) + int'($past(err_evt))) + int'($past(hist_q)) / 2));

  assert_write_load_R4: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    warm_rst_n && wr_en |=> cnt_q == $past(wr_data) && hist_q == '0);

  assert_write_flag_R5: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    warm_rst_n && wr_en && (wr_data > thresh) |=> over_thresh || (thresh != $past(thresh)));

  assert_warm_hold_R6: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    !warm_rst_n |=> $stable(cnt_q) && $stable(hist_q));
endmodule

bind leaky_err_counter leaky_err_counter_chk #(.CW(CW)) u_chk (
  .clk(clk), .pwr_rst_n(pwr_rst_n), .warm_rst_n(warm_rst_n), .err_evt(err_evt),
  .period_tick(period_tick), .wr_en(wr_en), .wr_data(wr_data), .thresh(thresh),
  .rd_data(rd_data), .over_thresh(over_thresh), .cnt_q(cnt_q), .hist_q(hist_q)
);

// File: tb/tb_leaky_err_counter.sv
module tb_leaky_err_counter;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 4;
  localparam int MAXI = (1 << CW) - 1;

  logic clk = 1'b0;
  logic pwr_rst_n = 1'b0, warm_rst_n = 1'b1;
  logic err_evt = 1'b0, period_tick = 1'b0, wr_en = 1'b0;
  logic [CW-1:0] wr_data = '0, thresh = '0;
  logic [CW-1:0] rd_data;
  logic over_thresh;

  int checks = 0, errors = 0;
  int mc = 0, mh = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  leaky_err_counter #(.CW(CW)) dut (
    .clk(clk), .pwr_rst_n(pwr_rst_n), .warm_rst_n(warm_rst_n), .err_evt(err_evt),
    .period_tick(period_tick), .wr_en(wr_en), .wr_data(wr_data), .thresh(thresh),
    .rd_data(rd_data), .over_thresh(over_thresh)
  );

  function automatic int sat(input int x);
    return (x > MAXI) ? MAXI : x;
  endfunction

  task automatic chk(input string req);
    int lvl = mc + mh / 2;
    int exp_rd = sat(lvl);
    bit exp_fl = lvl > int'(thresh);
    checks++;
    if (int'(rd_data) != exp_rd || over_thresh != exp_fl) begin
      errors++;
      $display("FAIL %s: rd_data=%0d flag=%0b expected rd_data=%0d flag=%0b",
               req, rd_data, over_thresh, exp_rd, exp_fl);
    end
  endtask

  task automatic cyc(input bit e, input bit t, input bit w, input int d);
    @(negedge clk);
    err_evt = e; period_tick = t; wr_en = w; wr_data = CW'(d);
    @(posedge clk);
    #1;
    if (warm_rst_n) begin
      if (w) begin mc = d; mh = 0; end
      else if (t) begin mh = sat(sat(mc + int'(e)) + mh / 2); mc = 0; end
      else if (e) mc = sat(mc + 1);
    end
    err_evt = 1'b0; period_tick = 1'b0; wr_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3);
    chk("R7 reset state");
    @(negedge clk);
    pwr_rst_n = 1'b1;

    // R4 / R5: every write value against every threshold
    for (int th = 0; th <= MAXI; th++) begin
      thresh = CW'(th);
      for (int d = 0; d <= MAXI; d++) begin
        cyc(0, 0, 1, d);
        chk("R4 R5 write sweep");
      end
    end

    // R2 / R3 / R1: tick folding, event runs to saturation, decay
    thresh = CW'(MAXI);
    for (int a = 0; a <= MAXI; a++) begin
      cyc(0, 0, 1, a);
      cyc(0, 1, 0, 0);
      chk("R3 tick fold");
      for (int k = 0; k < MAXI + 3; k++) begin
        cyc(1, 0, 0, 0);
        chk("R2 R1 event count");
      end
      cyc(0, 1, 0, 0);
      chk("R3 second tick");
      cyc(0, 1, 0, 0);
      chk("R3 decay");
      cyc(1, 1, 0, 0);
      chk("R3 event with tick");
    end

    // R4: write priority over event and tick
    thresh = 4'd3;
    cyc(0, 0, 1, 9);
    cyc(0, 1, 0, 0);
    cyc(1, 0, 1, 2);
    chk("R4 write beats event");
    cyc(1, 1, 1, 5);
    chk("R4 write beats tick");
    cyc(1, 1, 0, 0);
    chk("R3 event lands in ending period");

    // R6: warm reset holds state
    cyc(0, 0, 1, 7);
    cyc(0, 1, 0, 0);
    cyc(1, 0, 0, 0);
    @(negedge clk);
    warm_rst_n = 1'b0;
    cyc(1, 0, 0, 0);
    chk("R6 event ignored");
    cyc(0, 1, 0, 0);
    chk("R6 tick ignored");
    cyc(0, 0, 1, 15);
    chk("R6 write ignored");
    @(negedge clk);
    warm_rst_n = 1'b1;
    #1;
    chk("R6 state kept after warm reset");

    // R7: power reset clears
    @(negedge clk);
    pwr_rst_n = 1'b0;
    thresh = '0;
    mc = 0; mh = 0;
    #1;
    chk("R7 power reset clears");
    @(negedge clk);
    pwr_rst_n = 1'b1;
    cyc(1, 0, 0, 0);
    chk("R2 count after power reset");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule